// File: doc/BRIEF.md
# Banked GPIO Controller with Atomic Set/Clear

The controller drives and samples a parameterised number of general-purpose pins, grouped into banks of up to 32 pins. Each bank has its own group of 32-bit words in a flat byte-addressed register space. Software can pick a pin's direction, and it can load the output latch whole. It can also change chosen latch bits with write-one-to-set and write-one-to-clear words, so no read-modify-write sequence is needed. The input word returns the pin levels after they pass through a two-flop synchronizer.

The register port is a simple single-beat interface with a request, write-enable, address and write data. Read data is registered and appears in the cycle after the request. The edge-interrupt words share each bank's address window, but another block implements them. Here they read as zero and ignore writes. When the pin count is not a multiple of 32, the last bank has fewer pins. Its missing bits are not stored and always read as zero.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every implemented pin is an input (direction bits read 1, pin_oe_o all 0) and the output latch is 0 (pin_out_o all 0, output word reads 0).
- R2: Direction word (bank word 0): bit value 1 makes the pin an input with its driver off, and bit value 0 sets pin_oe_o for that pin from the next cycle on.
- R3: Output word (bank word 1): a write replaces the whole latch. The word reads back the latch, and pin_out_o follows from the cycle after the write.
- R4: Set word (bank word 2): each 1 in the written mask sets the matching latch bit, and each 0 leaves its bit unchanged.
- R5: Clear word (bank word 3): each 1 in the written mask clears the matching latch bit, and each 0 leaves its bit unchanged.
- R6: Reads of the set and clear words return zero.
- R7: Input word (bank word 4) returns pin_in_i through a two-flop synchronizer, for output pins as well as inputs. A read issued one cycle after a pin change still returns the old level.
- R8: Bank b occupies byte addresses 0x10 + 0x28*b upward, one 32-bit word per 4 bytes, in word order direction, output, set, clear, input. Bank words 5 to 9 and addresses outside every bank read zero, and writes to them change no state.
- R9: In a partly filled last bank, bits above the last implemented pin read zero in every word, and writes to them have no effect.
- R10: rdata_o takes the addressed word at the clock edge that accepts a read request and holds it until the next read request. Writes and idle cycles leave it unchanged.
- R11: A write to one bank leaves the latches and directions of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one beat |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pin_in_i | input | NUM_PINS | Asynchronous pin levels |
| pin_out_o | output | NUM_PINS | Output latch values |
| pin_oe_o | output | NUM_PINS | Output driver enables |

## Verification
The hardest case to reach from the ports is the synchronizer latency window. It needs a read that lands after exactly one clock edge following a pin change, while that pin is configured as an output. The bench first turns the last, partly filled bank into outputs. It then changes that bank's pin levels on a falling edge and issues the input-word read at once, so the read samples before the second flop has caught up. A second read then shows the new level. The bench also interleaves set, clear and whole-word writes across two banks, then reads words that no bank owns, to show that nothing leaks between windows.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int BANK_PINS   = 32;
  localparam int FIRST_OFS   = 16;
  localparam int BANK_STRIDE = 40;
  localparam int MAX_BANKS   = 5;

  // word order inside a bank window; interrupt words are decoded by a neighbour
  typedef enum logic [3:0] {
    W_DIR  = 4'd0,
    W_OUT  = 4'd1,
    W_SET  = 4'd2,
    W_CLR  = 4'd3,
    W_IN   = 4'd4,
    W_RSET = 4'd5,
    W_RCLR = 4'd6,
    W_FSET = 4'd7,
    W_FCLR = 4'd8,
    W_STAT = 4'd9
  } word_e;

  function automatic int bank_base(int b);
    return FIRST_OFS + b * BANK_STRIDE;
  endfunction

  function automatic int bank_width(int num_pins, int b);
    int rem;
    rem = num_pins - b * BANK_PINS;
    return (rem > BANK_PINS) ? BANK_PINS : rem;
  endfunction
endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_ctrl_dec.sv
module gpio_ctrl_dec
  import gpio_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 3
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] hit_o,
  output logic [3:0]           word_o
);
  logic [3:0] word_b [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
    localparam int BASE = bank_base(b);
    logic in_win;
    assign in_win = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + BANK_STRIDE)
                    && (addr_i[1:0] == 2'b00);
    assign hit_o[b]  = in_win;
    assign word_b[b] = in_win ? 4'((int'(addr_i) - BASE) >> 2) : 4'd0;
  end

  always_comb begin
    word_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) word_o = word_o | word_b[b];
  end
endmodule

// File: rtl/gpio_ctrl_bank.sv
module gpio_ctrl_bank
  import gpio_ctrl_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [3:0]       word_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [31:0]      rword_o,
  output logic [WIDTH-1:0] pin_o,
  output logic [WIDTH-1:0] oe_o
);
  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] out_q, out_d;
  logic [WIDTH-1:0] in_sync;

  gpio_ctrl_sync #(.WIDTH(WIDTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (in_sync)
  );

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    if (wr_i) begin
      unique case (word_e'(word_i))
        W_DIR:   dir_d = wdata_i;
        W_OUT:   out_d = wdata_i;
        W_SET:   out_d = out_q | wdata_i;
        W_CLR:   out_d = out_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  always_comb begin
    unique case (word_e'(word_i))
      W_DIR:   rword_o = 32'(dir_q);
      W_OUT:   rword_o = 32'(out_q);
      W_IN:    rword_o = 32'(in_sync);
      default: rword_o = '0;
    endcase
  end

  assign pin_o = out_q;
  assign oe_o  = ~dir_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int NUM_PINS = 72,
  parameter int ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_in_i,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;

  logic [NUM_BANKS-1:0] hit;
  logic [3:0]           word;
  logic [31:0]          rword [NUM_BANKS];
  logic [31:0]          rsel;
  logic [31:0]          rdata_q;

  gpio_ctrl_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .word_o (word)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W  = bank_width(NUM_PINS, b);
    localparam int LO = b * BANK_PINS;
    gpio_ctrl_bank #(.WIDTH(W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (req_i && we_i && hit[b]),
      .word_i  (word),
      .wdata_i (wdata_i[W-1:0]),
      .pin_i   (pin_in_i[LO +: W]),
      .rword_o (rword[b]),
      .pin_o   (pin_out_o[LO +: W]),
      .oe_o    (pin_oe_o[LO +: W])
    );
  end

  always_comb begin
    rsel = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hit[b]) rsel = rsel | rword[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rsel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NUM_PINS = 72,
  parameter int ADDR_W   = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pin_out_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  a_r2_dir_in_drops_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h10) && wdata_i[0] |=> !pin_oe_o[0]);

  a_r2_dir_out_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h10) && !wdata_i[0] |=> pin_oe_o[0]);

  a_r3_latch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(pin_out_o));

  a_r4_set_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h18) && wdata_i[0] |=> pin_out_o[0]);

  a_r4_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h18) && !wdata_i[0] |=> pin_out_o[0] == $past(pin_out_o[0]));

  a_r5_clr_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'(8'h1C) && wdata_i[0] |=> !pin_out_o[0]);

  a_r6_set_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i == ADDR_W'(8'h18) || addr_i == ADDR_W'(8'h1C)) |=> rdata_o == 32'h0);

  a_r8_low_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && addr_i < ADDR_W'(8'h10) |=> rdata_o == 32'h0);

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_out_o (pin_out_o),
  .pin_oe_o  (pin_oe_o)
);

// File: tb/gpio_ctrl_tb.sv
module gpio_ctrl_tb;
  localparam int NP = 72;
  localparam int AW = 8;
  localparam int NV = 27;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pin_in_i = '0;
  logic [NP-1:0] pin_out_o, pin_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_in_i(pin_in_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o)
  );

  // {we, addr, wdata, expected read, requirement number}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 8'h10, 32'h0,        32'hFFFF_FFFF, 4'd1},  // R1 dir resets to inputs
    {1'b0, 8'h60, 32'h0,        32'h0000_00FF, 4'd9},  // R9 partial bank dir
    {1'b0, 8'h14, 32'h0,        32'h0000_0000, 4'd1},  // R1 latch zero
    {1'b1, 8'h14, 32'h1234_5678, 32'h0,        4'd3},  // R3 whole write
    {1'b0, 8'h14, 32'h0,        32'h1234_5678, 4'd3},
    {1'b1, 8'h18, 32'h0000_000F, 32'h0,        4'd4},  // R4 set mask
    {1'b0, 8'h14, 32'h0,        32'h1234_567F, 4'd4},
    {1'b1, 8'h1C, 32'h0000_0070, 32'h0,        4'd5},  // R5 clear mask
    {1'b0, 8'h14, 32'h0,        32'h1234_560F, 4'd5},
    {1'b0, 8'h18, 32'h0,        32'h0000_0000, 4'd6},  // R6 set reads zero
    {1'b0, 8'h1C, 32'h0,        32'h0000_0000, 4'd6},  // R6 clear reads zero
    {1'b0, 8'h20, 32'h0,        32'hA5A5_0F0F, 4'd7},  // R7 input word
    {1'b1, 8'h64, 32'hFFFF_FFFF, 32'h0,        4'd9},  // R9 write past last pin
    {1'b0, 8'h64, 32'h0,        32'h0000_00FF, 4'd9},
    {1'b1, 8'h3C, 32'hCAFE_F00D, 32'h0,        4'd11}, // R11 second bank
    {1'b0, 8'h3C, 32'h0,        32'hCAFE_F00D, 4'd11},
    {1'b0, 8'h14, 32'h0,        32'h1234_560F, 4'd11},
    {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0,        4'd8},  // R8 interrupt word
    {1'b0, 8'h24, 32'h0,        32'h0000_0000, 4'd8},
    {1'b0, 8'h14, 32'h0,        32'h1234_560F, 4'd8},
    {1'b0, 8'h08, 32'h0,        32'h0000_0000, 4'd8},  // R8 below first bank
    {1'b1, 8'h0C, 32'hDEAD_BEEF, 32'h0,        4'd8},
    {1'b0, 8'h88, 32'h0,        32'h0000_0000, 4'd8},  // R8 beyond last bank
    {1'b1, 8'h10, 32'hFFFF_0000, 32'h0,        4'd2},  // R2 direction write
    {1'b0, 8'h10, 32'h0,        32'hFFFF_0000, 4'd2},
    {1'b1, 8'h60, 32'hFFFF_FF00, 32'h0,        4'd9},  // R9 bank 2 all outputs
    {1'b0, 8'h60, 32'h0,        32'h0000_0000, 4'd9}
  };

  task automatic check(string tag, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    pin_in_i = {8'h00, 32'h0, 32'hA5A5_0F0F};
    repeat (3) @(negedge clk_i);
    check("R1 oe after reset", 72'(pin_oe_o), 72'h0);
    check("R1 out after reset", 72'(pin_out_o), 72'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] e;
      e = VEC[i];
      if (e[76]) bus_write(e[75:68], e[67:36]);
      else begin
        bus_read(e[75:68], rd);
        check($sformatf("R%0d vec %0d addr %h", e[3:0], i, e[75:68]), 72'(rd), 72'(e[35:4]));
      end
    end

    check("R2 oe bank0", 72'(pin_oe_o[31:0]), 72'h0000_FFFF);
    check("R2 oe bank2", 72'(pin_oe_o[71:64]), 72'hFF);
    check("R3 pins bank0", 72'(pin_out_o[31:0]), 72'h1234_560F);
    check("R9 pins bank2", 72'(pin_out_o[71:64]), 72'hFF);
    check("R11 pins bank1", 72'(pin_out_o[63:32]), 72'hCAFE_F00D);

    // R7 synchronizer latency on output pins
    @(negedge clk_i);
    pin_in_i[71:64] = 8'h3C;
    bus_read(8'h70, rd);
    check("R7 read one edge after change", 72'(rd), 72'h00);
    bus_read(8'h70, rd);
    check("R7 read after sync", 72'(rd), 72'h3C);

    // R10 hold across idle and write
    @(negedge clk_i);
    check("R10 hold idle", 72'(rdata_o), 72'h3C);
    bus_write(8'h14, 32'h0);
    check("R10 hold over write", 72'(rdata_o), 72'h3C);

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 oe async reset", 72'(pin_oe_o), 72'h0);
    check("R1 out async reset", 72'(pin_out_o), 72'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_read(8'h3C, rd);
    check("R1 latch after reset", 72'(rd), 72'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule